// File: doc/BRIEF.md
# Sticky Interrupt Status Bank with Clear-on-Read

This block collects single-cycle event pulses from an HDLC and signaling channel and holds each one in a sticky status bit. Every bit has a mask bit. Unmasked pending bits drive one active-high interrupt line and a global summary bit. A visibility control lets masked events be latched, so software can poll for them without being interrupted. A read of the status register returns the whole bank and clears it in the same cycle.

Two event roles are qualified before they are latched. The all-sent event counts only while the channel runs in HDLC mode. The transmit-signaling-empty event is dropped while serial signaling access is enabled. A transmit underrun also raises a transmit lockout output. That output holds the transmitter and its FIFO disabled until the processor reads the status register.

Top module: `irq_status_bank`

## Requirements
- R1: After reset the status bank reads 0x00, the mask reads 0xFF, the control register reads 0x00, the summary reads 0x00, and both `irq_o` and `tx_lockout_o` are low.
- R2: An event pulse on an unmasked bit sets that status bit, and the bit stays set until a status read.
- R3: A read at address 0 returns the status bank and clears every bit in it, so the next read returns 0x00 if no new event arrives.
- R4: An event pulse in the same cycle as a clearing read is kept, so the following status read shows it.
- R5: With the visibility bit (control bit 0) at 0, an event on a masked bit (mask bit 1) is not latched.
- R6: With the visibility bit at 1, an event on a masked bit is latched and can be read at address 0.
- R7: `irq_o` is high exactly when, in the previous cycle, some status bit was set with its mask bit 0. Masked bits never raise it.
- R8: Bit 0 of address 3 reads 1 only when some status bit is set with its mask bit 0. The other bits of address 3 read 0.
- R9: An event on bit 0 (underrun) raises `tx_lockout_o` in the next cycle, whatever its mask. The output stays high until a status read. An underrun in the same cycle as that read keeps it high.
- R10: An event on bit 1 (all-sent) is ignored while `hdlc_mode_i` is low.
- R11: An event on bit 3 (signaling empty) is ignored while `ser_sig_en_i` is high.
- R12: Read data appears on `rd_data_o` one cycle after `rd_en_i` and holds until the next read. Reads at addresses 1 to 3 clear nothing. Writes at address 1 set the mask and writes at address 2 set the control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Single-cycle event pulses, one per status bit |
| hdlc_mode_i | input | 1 | High while the channel runs in HDLC mode |
| ser_sig_en_i | input | 1 | High while serial signaling access is enabled |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 2 | Read address: 0 status, 1 mask, 2 control, 3 summary |
| rd_data_o | output | 8 | Registered read data |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write address: 1 mask, 2 control |
| wr_data_i | input | 8 | Write data |
| irq_o | output | 1 | Active-high interrupt |
| tx_lockout_o | output | 1 | Transmitter and FIFO hold after an underrun |

## Verification
Some rules are checked by assertions on every cycle. Status bits never fall without a clearing read. A masked event never sets a bit while visibility is off. An ungated all-sent bit cannot appear outside HDLC mode. An underrun always raises the lockout, and the lockout only drops after a read. An empty bank is always followed by a low interrupt. Other behaviour can only be shown by the bench scenarios: the exact values returned by reads, an event kept across a same-cycle clear, visibility-latched bits staying out of the interrupt and the summary, and the one-cycle latency of the registered outputs. The bench compares these against a reference model built from the requirements.

// File: rtl/irqsb_pkg.sv
package irqsb_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      RA_STATUS  = 2'd0,
      RA_MASK    = 2'd1,
      RA_CTRL    = 2'd2,
      RA_SUMMARY = 2'd3
   } reg_addr_e;

   localparam int CTRL_VIS_BIT = 0;
endpackage

// File: rtl/irqsb_qualify.sv
module irqsb_qualify #(
   parameter int NUM_EVT      = 8,
   parameter int ALLSENT_BIT  = 1,
   parameter int SIGEMPTY_BIT = 3
) (
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic               hdlc_mode_i,
   input  logic               ser_sig_en_i,
   output logic [NUM_EVT-1:0] qual_o
);
   for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
      if (i == ALLSENT_BIT) begin : g_allsent
         assign qual_o[i] = evt_i[i] & hdlc_mode_i;
      end else if (i == SIGEMPTY_BIT) begin : g_sigempty
         assign qual_o[i] = evt_i[i] & ~ser_sig_en_i;
      end else begin : g_plain
         assign qual_o[i] = evt_i[i];
      end
   end
endmodule

// File: rtl/irqsb_cfg.sv
module irqsb_cfg #(
   parameter int NUM_EVT = 8,
   parameter int DATA_W  = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en_i,
   input  logic [irqsb_pkg::ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0]            wr_data_i,
   output logic [NUM_EVT-1:0]           mask_o,
   output logic                         vis_o
);
   import irqsb_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_o <= '1;
         vis_o  <= 1'b0;
      end else if (wr_en_i) begin
         if (wr_addr_i == RA_MASK) mask_o <= wr_data_i[NUM_EVT-1:0];
         if (wr_addr_i == RA_CTRL) vis_o  <= wr_data_i[CTRL_VIS_BIT];
      end
   end
endmodule

// File: rtl/irqsb_latch.sv
module irqsb_latch #(
   parameter int NUM_EVT     = 8,
   parameter int ALLSENT_BIT = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] qual_i,
   input  logic [NUM_EVT-1:0] mask_i,
   input  logic               vis_i,
   input  logic               clr_i,
   input  logic               hdlc_mode_i,
   output logic [NUM_EVT-1:0] status_o
);
   logic [NUM_EVT-1:0] accept;
   logic [NUM_EVT-1:0] status_d;

   always_comb begin
      accept   = qual_i & (~mask_i | {NUM_EVT{vis_i}});
      status_d = (clr_i ? '0 : status_o) | accept;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_o <= '0;
      else        status_o <= status_d;
   end

   // R2: bits are sticky unless a clearing read occurs
   a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (($past(status_o) & ~status_o) == '0));

   // R3: a clearing read with no incoming event empties the bank
   a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && (qual_i == '0)) |=> (status_o == '0));

   // R5: with visibility off, a masked event sets nothing new
   a_r5_masked_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      !vis_i |=> ((status_o & ~$past(status_o) & $past(mask_i)) == '0));

   // R10: all-sent cannot appear outside HDLC mode
   a_r10_allsent_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!hdlc_mode_i && !status_o[ALLSENT_BIT]) |=> !status_o[ALLSENT_BIT]);
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int NUM_EVT      = 8,
   parameter int DATA_W       = 8,
   parameter int UNDERRUN_BIT = 0,
   parameter int ALLSENT_BIT  = 1,
   parameter int SIGEMPTY_BIT = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_EVT-1:0]           evt_i,
   input  logic                         hdlc_mode_i,
   input  logic                         ser_sig_en_i,
   input  logic                         rd_en_i,
   input  logic [irqsb_pkg::ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0]            rd_data_o,
   input  logic                         wr_en_i,
   input  logic [irqsb_pkg::ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0]            wr_data_i,
   output logic                         irq_o,
   output logic                         tx_lockout_o
);
   import irqsb_pkg::*;

   localparam int PAD_W = DATA_W - NUM_EVT;

   if (NUM_EVT > DATA_W) begin : g_bad_width
      $error("irq_status_bank: NUM_EVT exceeds DATA_W");
   end
   if (UNDERRUN_BIT >= NUM_EVT || ALLSENT_BIT >= NUM_EVT || SIGEMPTY_BIT >= NUM_EVT) begin : g_bad_role
      $error("irq_status_bank: event role index out of range");
   end

   logic [NUM_EVT-1:0] qual;
   logic [NUM_EVT-1:0] mask;
   logic [NUM_EVT-1:0] status;
   logic               vis;
   logic               clr;
   logic               pending;
   logic [DATA_W-1:0]  st_ext;
   logic [DATA_W-1:0]  mask_ext;
   logic [DATA_W-1:0]  rd_mux;

   assign clr     = rd_en_i && (rd_addr_i == RA_STATUS);
   assign pending = |(status & ~mask);

   irqsb_qualify #(
      .NUM_EVT(NUM_EVT), .ALLSENT_BIT(ALLSENT_BIT), .SIGEMPTY_BIT(SIGEMPTY_BIT)
   ) u_qual (
      .evt_i(evt_i), .hdlc_mode_i(hdlc_mode_i), .ser_sig_en_i(ser_sig_en_i), .qual_o(qual)
   );

   irqsb_cfg #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .mask_o(mask), .vis_o(vis)
   );

   irqsb_latch #(.NUM_EVT(NUM_EVT), .ALLSENT_BIT(ALLSENT_BIT)) u_latch (
      .clk(clk), .rst_n(rst_n), .qual_i(qual), .mask_i(mask), .vis_i(vis),
      .clr_i(clr), .hdlc_mode_i(hdlc_mode_i), .status_o(status)
   );

   if (PAD_W > 0) begin : g_pad
      assign st_ext   = {{PAD_W{1'b0}}, status};
      assign mask_ext = {{PAD_W{1'b0}}, mask};
   end else begin : g_nopad
      assign st_ext   = status;
      assign mask_ext = mask;
   end

   always_comb begin
      rd_mux = '0;
      unique case (rd_addr_i)
         RA_STATUS:  rd_mux = st_ext;
         RA_MASK:    rd_mux = mask_ext;
         RA_CTRL:    rd_mux[CTRL_VIS_BIT] = vis;
         RA_SUMMARY: rd_mux[0] = pending;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_o    <= '0;
         irq_o        <= 1'b0;
         tx_lockout_o <= 1'b0;
      end else begin
         if (rd_en_i) rd_data_o <= rd_mux;
         irq_o        <= pending;
         tx_lockout_o <= evt_i[UNDERRUN_BIT] | (tx_lockout_o & ~clr);
      end
   end

   // R9: an underrun always raises the lockout in the next cycle
   a_r9_lockout_set: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[UNDERRUN_BIT] |=> tx_lockout_o);

   // R9: the lockout only drops after a status read
   a_r9_lockout_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_lockout_o && !clr) |=> tx_lockout_o);

   // R7: an empty bank is followed by a low interrupt
   a_r7_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (status == '0) |=> !irq_o);

   // R12: read data holds while no read is issued
   a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: tb/tb_irq_status_bank.sv
module tb_irq_status_bank;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] evt_i = '0;
   logic       hdlc_mode_i = 1'b0;
   logic       ser_sig_en_i = 1'b0;
   logic       rd_en_i = 1'b0;
   logic [1:0] rd_addr_i = '0;
   logic [7:0] rd_data_o;
   logic       wr_en_i = 1'b0;
   logic [1:0] wr_addr_i = '0;
   logic [7:0] wr_data_i = '0;
   logic       irq_o;
   logic       tx_lockout_o;

   int n_cmp = 0;
   int n_bad = 0;

   // reference model state
   logic [7:0] m_st = '0;
   logic [7:0] m_mask = 8'hFF;
   logic       m_vis = 1'b0;
   logic       m_lock = 1'b0;
   logic       m_irq = 1'b0;
   logic [7:0] m_rd = '0;

   always #10 clk = ~clk;

   irq_status_bank dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .hdlc_mode_i(hdlc_mode_i),
      .ser_sig_en_i(ser_sig_en_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
      .rd_data_o(rd_data_o), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .irq_o(irq_o), .tx_lockout_o(tx_lockout_o)
   );

   function automatic logic [7:0] qualify(logic [7:0] e, logic hm, logic ss);
      logic [7:0] q = e;
      if (!hm) q[1] = 1'b0;  // R10
      if (ss)  q[3] = 1'b0;  // R11
      return q;
   endfunction

   function automatic logic [7:0] read_value(logic [1:0] a);
      case (a)
         2'd0:    return m_st;
         2'd1:    return m_mask;
         2'd2:    return {7'b0, m_vis};
         default: return {7'b0, |(m_st & ~m_mask)};
      endcase
   endfunction

   task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(string tag, logic [7:0] e, logic hm, logic ss,
                      logic re, logic [1:0] ra, logic we, logic [1:0] wa, logic [7:0] wd);
      logic [7:0] q, n_st, n_rd;
      logic n_lock, n_irq, clr;
      evt_i = e; hdlc_mode_i = hm; ser_sig_en_i = ss;
      rd_en_i = re; rd_addr_i = ra; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
      q      = qualify(e, hm, ss);
      clr    = re && (ra == 2'd0);
      n_rd   = re ? read_value(ra) : m_rd;
      n_st   = (clr ? 8'h00 : m_st) | (q & (~m_mask | {8{m_vis}}));
      n_lock = e[0] | (m_lock & ~clr);
      n_irq  = |(m_st & ~m_mask);
      @(posedge clk);
      #1;
      m_st = n_st; m_lock = n_lock; m_irq = n_irq; m_rd = n_rd;
      if (we && wa == 2'd1) m_mask = wd;
      if (we && wa == 2'd2) m_vis = wd[0];
      @(negedge clk);
      check(tag, "rd_data", rd_data_o, m_rd);
      check(tag, "irq", {7'b0, irq_o}, {7'b0, m_irq});
      check(tag, "lockout", {7'b0, tx_lockout_o}, {7'b0, m_lock});
   endtask

   task automatic idle(string tag);
      cyc(tag, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 8'h00);
   endtask
   task automatic rd(string tag, logic [1:0] a);
      cyc(tag, 8'h00, 1'b1, 1'b0, 1'b1, a, 1'b0, 2'd0, 8'h00);
   endtask
   task automatic wr(string tag, logic [1:0] a, logic [7:0] d);
      cyc(tag, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, a, d);
   endtask
   task automatic ev(string tag, logic [7:0] e, logic hm, logic ss);
      cyc(tag, e, hm, ss, 1'b0, 2'd0, 1'b0, 2'd0, 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", "irq", {7'b0, irq_o}, 8'h00);
      check("R1", "lockout", {7'b0, tx_lockout_o}, 8'h00);
      rd("R1", 2'd1); check("R1", "mask", rd_data_o, 8'hFF);
      rd("R1", 2'd2); check("R1", "ctrl", rd_data_o, 8'h00);
      rd("R1", 2'd3); check("R1", "summary", rd_data_o, 8'h00);
      rd("R1", 2'd0); check("R1", "status", rd_data_o, 8'h00);

      // R2 / R7 / R8: unmasked event
      wr("R12", 2'd1, 8'h00);
      ev("R2", 8'h04, 1'b1, 1'b0);
      idle("R7");
      check("R7", "irq", {7'b0, irq_o}, 8'h01);
      rd("R8", 2'd3); check("R8", "summary", rd_data_o, 8'h01);
      rd("R12", 2'd1); check("R12", "mask", rd_data_o, 8'h00);
      rd("R2", 2'd0); check("R2", "status", rd_data_o, 8'h04);
      // R3: second read is empty
      rd("R3", 2'd0); check("R3", "status", rd_data_o, 8'h00);

      // R4: event with clearing read survives
      ev("R4", 8'h40, 1'b1, 1'b0);
      cyc("R4", 8'h10, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 8'h00);
      check("R4", "old", rd_data_o, 8'h40);
      rd("R4", 2'd0); check("R4", "new", rd_data_o, 8'h10);

      // R5: masked, visibility off
      wr("R5", 2'd1, 8'hFF);
      ev("R5", 8'h20, 1'b1, 1'b0);
      rd("R5", 2'd0); check("R5", "status", rd_data_o, 8'h00);

      // R6: masked, visibility on, no interrupt and no summary
      wr("R6", 2'd2, 8'h01);
      rd("R12", 2'd2); check("R12", "ctrl", rd_data_o, 8'h01);
      ev("R6", 8'h20, 1'b1, 1'b0);
      idle("R7");
      idle("R7");
      check("R7", "irq", {7'b0, irq_o}, 8'h00);
      rd("R8", 2'd3); check("R8", "summary", rd_data_o, 8'h00);
      rd("R6", 2'd0); check("R6", "status", rd_data_o, 8'h20);
      wr("R6", 2'd2, 8'h00);

      // R9: underrun lockout while masked
      ev("R9", 8'h01, 1'b1, 1'b0);
      check("R9", "lockout", {7'b0, tx_lockout_o}, 8'h01);
      idle("R9");
      rd("R12", 2'd1);
      rd("R12", 2'd3);
      check("R12", "lockout", {7'b0, tx_lockout_o}, 8'h01);
      cyc("R9", 8'h01, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 8'h00);
      check("R9", "lockout", {7'b0, tx_lockout_o}, 8'h01);
      rd("R9", 2'd0);
      check("R9", "lockout", {7'b0, tx_lockout_o}, 8'h00);

      // R10 / R11: role gating
      wr("R10", 2'd1, 8'h00);
      ev("R10", 8'h02, 1'b0, 1'b0);
      rd("R10", 2'd0); check("R10", "status", rd_data_o, 8'h00);
      ev("R10", 8'h02, 1'b1, 1'b0);
      rd("R10", 2'd0); check("R10", "status", rd_data_o, 8'h02);
      ev("R11", 8'h08, 1'b1, 1'b1);
      rd("R11", 2'd0); check("R11", "status", rd_data_o, 8'h00);
      ev("R11", 8'h08, 1'b1, 1'b0);
      rd("R11", 2'd0); check("R11", "status", rd_data_o, 8'h08);

      // random mix, every cycle compared against the model (R2 R3 R7 R9 R12)
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] e;
         e = 8'($urandom) & 8'($urandom) & 8'($urandom);
         cyc("R7/R2", e, 1'($urandom), 1'($urandom % 4 == 0),
             1'($urandom % 4 == 0), 2'($urandom),
             1'($urandom % 8 == 0), 2'($urandom), 8'($urandom));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule